// File: doc/BRIEF.md
# Continuation-Flag Integer Byte Encoder

This block takes one 32-bit unsigned integer at a time and turns it into the shortest byte sequence that can hold its value. Each output byte carries seven payload bits in its low positions. Its top bit is a continuation flag: the flag says whether more bytes of the same integer follow. The lowest seven-bit group goes out first. Small values therefore take one byte, and the full 32-bit range takes at most five.

Integers arrive on a valid/ready input handshake. Bytes leave on a valid/ready output, and a separate last marker flags the final byte of each integer. The block holds a single integer at a time. It refuses the next one until the last byte of the current one has been taken.

Top module: `varint_byte_encoder`

## Requirements
- R1: A value from 0 to 127 produces exactly one byte. Bit 7 of that byte is 0 and bits 6..0 equal the value.
- R2: Bit 7 of every emitted byte is 1 when further bytes of the same integer follow, and 0 on its final byte.
- R3: The byte count follows the highest set bit. Values in [2^7, 2^14) take 2 bytes, [2^14, 2^21) take 3, [2^21, 2^28) take 4, and [2^28, 2^32) take 5.
- R4: Groups are emitted least significant first, and byte k carries value bits 7k+6..7k. For example, 1729 is sent as 0xC1 then 0x0D.
- R5: The fifth byte of a 5-byte integer has bits 3..0 equal to input bits 31..28, and bits 7..4 equal to zero.
- R6: The value 0 produces a single 0x00 byte.
- R7: in_ready is low while any byte of the held integer is still unsent. An in_valid presented during that time is not accepted.
- R8: While out_valid is high and out_ready is low, out_valid stays high and out_byte and out_last hold their values.
- R9: out_last is high on the final byte of each integer and low on every other byte.
- R10: A synchronous active-high reset discards any partly sent integer, drops out_valid and raises in_ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | An integer is offered on in_data |
| in_ready | output | 1 | The block can take an integer |
| in_data | input | 32 | Unsigned integer to encode |
| out_valid | output | 1 | out_byte holds an encoded byte |
| out_ready | input | 1 | The consumer takes out_byte this cycle |
| out_byte | output | 8 | Encoded byte, with the continuation flag in bit 7 |
| out_last | output | 1 | This is the final byte of the integer |

## Verification
The bench targets the values on each side of every byte-count boundary (127/128, 16383/16384, 2^21, 2^28) and the two extremes, zero and all ones. A design with an off-by-one in its length logic would send one byte too many, ending in a trailing 0x00, or one too few, dropping high bits. A wrong group order would emit 0x0D before 0xC1 for 1729. A missing mask on the fifth byte would show flag bits or junk in its upper nibble. The bench also holds in_valid high with a spare value throughout each integer. A block that admitted it early would corrupt the stream or emit an extra integer. Back-pressure on selected bytes would expose an output that advances without out_ready. A reset issued in the middle of an integer would expose leftover bytes.

// File: rtl/varint_pkg.sv
package varint_pkg;
  localparam int VBE_DATA_W  = 32;
  localparam int VBE_GROUP_W = 7;

  // number of payload groups needed to cover a word of width w
  function automatic int groups_for(input int w, input int g);
    return (w + g - 1) / g;
  endfunction
endpackage

// File: rtl/vbe_sizer.sv
module vbe_sizer
  import varint_pkg::*;
#(
  parameter int DATA_W  = VBE_DATA_W,
  parameter int GROUP_W = VBE_GROUP_W,
  parameter int CNT_W   = 3
) (
  input  logic [DATA_W-1:0] value,
  output logic [CNT_W-1:0]  byte_count
);
  localparam int MAX_BYTES = groups_for(DATA_W, GROUP_W);

  // count = index of the highest non-empty group, plus one; zero still needs one byte
  function automatic logic [CNT_W-1:0] count_groups(input logic [DATA_W-1:0] v);
    logic [CNT_W-1:0] c;
    c = CNT_W'(1);
    for (int i = 1; i < MAX_BYTES; i++) begin
      if ((v >> (GROUP_W * i)) != '0) c = CNT_W'(i + 1);
    end
    return c;
  endfunction

  assign byte_count = count_groups(value);

  // R3: the length stays inside the legal range
  always_comb begin
    a_r3_count_range: assert (byte_count >= CNT_W'(1) && byte_count <= CNT_W'(MAX_BYTES))
      else $error("byte count out of range");
  end
endmodule

// File: rtl/vbe_emitter.sv
module vbe_emitter
  import varint_pkg::*;
#(
  parameter int DATA_W  = VBE_DATA_W,
  parameter int GROUP_W = VBE_GROUP_W,
  parameter int CNT_W   = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [DATA_W-1:0]  load_value,
  input  logic [CNT_W-1:0]   load_count,
  input  logic               out_ready,
  output logic               out_valid,
  output logic [GROUP_W:0]   out_byte,
  output logic               out_last,
  output logic               busy
);
  logic [DATA_W-1:0] shreg;
  logic [CNT_W-1:0]  left;
  logic              byte_fire;
  logic              final_fire;

  assign busy       = (left != '0);
  assign out_valid  = busy;
  assign byte_fire  = out_valid && out_ready;
  assign final_fire = byte_fire && (left == CNT_W'(1));
  assign out_last   = (left == CNT_W'(1));
  assign out_byte   = {(left > CNT_W'(1)), shreg[GROUP_W-1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg <= '0;
      left  <= '0;
    end else if (load) begin
      shreg <= load_value;
      left  <= load_count;
    end else if (byte_fire) begin
      shreg <= shreg >> GROUP_W;
      left  <= left - CNT_W'(1);
    end
  end

  // R8: a stalled byte holds
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_byte) && $stable(out_last));
  // R2: flag bit and last marker are complementary
  a_r2_flag: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_byte[GROUP_W] == !out_last));
  // R3: by the last byte nothing above the low group remains
  a_r3_drained: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_last |-> ((shreg >> GROUP_W) == '0));
  // R7: no load while bytes are pending
  a_r7_no_reload: assert property (@(posedge clk) disable iff (rst)
    busy |-> !load);
  // R9: after the final byte goes, the block is idle
  a_r9_idle_after_last: assert property (@(posedge clk) disable iff (rst)
    final_fire |=> !out_valid);
endmodule

// File: rtl/varint_byte_encoder.sv
module varint_byte_encoder
  import varint_pkg::*;
#(
  parameter int DATA_W  = VBE_DATA_W,
  parameter int GROUP_W = VBE_GROUP_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [GROUP_W:0]  out_byte,
  output logic              out_last
);
  localparam int MAX_BYTES = groups_for(DATA_W, GROUP_W);
  localparam int CNT_W     = $clog2(MAX_BYTES + 1);

  logic [CNT_W-1:0] count;
  logic             busy;
  logic             accept;

  assign in_ready = !busy;
  assign accept   = in_valid && in_ready;

  vbe_sizer #(.DATA_W(DATA_W), .GROUP_W(GROUP_W), .CNT_W(CNT_W)) u_sizer (
    .value      (in_data),
    .byte_count (count)
  );

  vbe_emitter #(.DATA_W(DATA_W), .GROUP_W(GROUP_W), .CNT_W(CNT_W)) u_emit (
    .clk        (clk),
    .rst        (rst),
    .load       (accept),
    .load_value (in_data),
    .load_count (count),
    .out_ready  (out_ready),
    .out_valid  (out_valid),
    .out_byte   (out_byte),
    .out_last   (out_last),
    .busy       (busy)
  );

  // R10: reset leaves the block idle
  a_r10_reset_idle: assert property (@(posedge clk) rst |=> !out_valid && in_ready);
  // R1: an accepted integer shows its first byte on the next cycle
  a_r1_first_byte: assert property (@(posedge clk) disable iff (rst)
    accept |=> out_valid);
endmodule

// File: tb/sim_varint_byte_encoder.sv
`timescale 1ns/1ps
module sim_varint_byte_encoder;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic        in_ready;
  logic [31:0] in_data;
  logic        out_valid;
  logic        out_ready;
  logic [7:0]  out_byte;
  logic        out_last;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  varint_byte_encoder u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_byte(out_byte), .out_last(out_last)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // reference encoding: peel groups until nothing is left
  task automatic ref_encode(input logic [31:0] v, output logic [7:0] b[5], output int n);
    logic [31:0] r;
    r = v;
    n = 0;
    for (int k = 0; k < 5; k++) b[k] = 8'h00;
    do begin
      b[n] = {1'b0, r[6:0]};
      r = r >> 7;
      if (r != 0) b[n][7] = 1'b1;
      n++;
    end while (r != 0);
  endtask

  // offer v; returns at the negedge after the accepting edge
  task automatic push(input logic [31:0] v);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = v;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = ~v;   // spare value held during the integer (R7)
  endtask

  task automatic run_value(input logic [31:0] v, input int stall_mod, input int exp_n, input string req);
    logic [7:0] e[5];
    int n;
    ref_encode(v, e, n);
    check(n == exp_n, req, n, exp_n);
    push(v);
    for (int i = 0; i < n; i++) begin
      check(out_valid == 1'b1, req, out_valid, 1);
      check(out_byte == e[i], req, out_byte, e[i]);
      check(out_last == (i == n - 1), "R9", out_last, (i == n - 1));
      check(out_byte[7] == (i != n - 1), "R2", out_byte[7], (i != n - 1));
      check(in_ready == 1'b0, "R7", in_ready, 0);
      if (stall_mod != 0 && (i % stall_mod) == 0) begin
        out_ready = 1'b0;
        @(negedge clk);
        check(out_valid && out_byte == e[i], "R8", out_byte, e[i]);
        check(out_last == (i == n - 1), "R8", out_last, (i == n - 1));
      end
      out_ready = 1'b1;
      @(negedge clk);
      out_ready = 1'b0;
    end
    in_valid = 1'b0;
    check(out_valid == 1'b0, "R7", out_valid, 0);
    check(in_ready == 1'b1, "R7", in_ready, 1);
  endtask

  task automatic t_reset_state();
    check(out_valid == 1'b0, "R10", out_valid, 0);
    check(in_ready == 1'b1, "R10", in_ready, 1);
  endtask

  task automatic t_small();
    run_value(32'd0, 0, 1, "R6");
    run_value(32'd17, 1, 1, "R1");
    run_value(32'd127, 0, 1, "R1");
  endtask

  task automatic t_boundaries();
    run_value(32'd128, 1, 2, "R3");
    run_value(32'd1729, 0, 2, "R4");
    run_value(32'd16383, 2, 2, "R3");
    run_value(32'd16384, 0, 3, "R3");
    run_value(32'h001F_FFFF, 2, 3, "R3");
    run_value(32'h0020_0000, 1, 4, "R3");
    run_value(32'h0FFF_FFFF, 3, 4, "R3");
    run_value(32'h1000_0000, 0, 5, "R5");
    run_value(32'hFFFF_FFFF, 1, 5, "R5");
    run_value(32'hA5C3_9E71, 2, 5, "R4");
  endtask

  task automatic t_fifth_byte();
    push(32'hB000_0000);
    out_ready = 1'b1;
    for (int i = 0; i < 4; i++) @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b0;
    check(out_byte == 8'h0B && out_last, "R5", out_byte, 8'h0B);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    check(!out_valid, "R5", out_valid, 0);
  endtask

  task automatic t_mid_reset();
    push(32'hFFFF_FFFF);
    in_valid = 1'b0;
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(out_valid == 1'b0, "R10", out_valid, 0);
    check(in_ready == 1'b1, "R10", in_ready, 1);
    run_value(32'd300, 0, 2, "R10");
  endtask

  initial begin
    rst = 1'b1; in_valid = 1'b0; in_data = '0; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset_state();
    t_small();
    t_boundaries();
    t_fifth_byte();
    t_mid_reset();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule